// File: doc/BRIEF.md
# Rounded Constant Divider

This block divides an unsigned 13-bit numerator by one of five small constant denominators (3, 5, 6, 7 or 9) and returns the quotient rounded to the nearest integer. A half is always rounded up. No multiplier and no general divider are used. The reciprocal of each denominator is applied as a sum of shifted copies of the numerator. That gives a quotient estimate that is exact or one too small. A remainder is then formed by shift-add and used to repair the estimate. A last stage adds one when the remainder is at least half of the denominator.

A request is a numerator, a denominator select and a strobe. The select value is the denominator itself, in binary. The unit is a fixed-latency pipeline and takes a new request on every clock. Each request carries its own select along with it, so requests with different denominators can be in flight together. The result appears with an output strobe a fixed number of cycles after the request.

Top module: `rnd_cdiv`

## Requirements
- R1: For a select value of 3, 5, 6, 7 or 9, the select value is the denominator d, and the output quotient equals floor((2n+d)/(2d)). This is n/d rounded to nearest, with ties rounded up.
- R2: The whole numerator range 0..8191 is handled, including both end values.
- R3: out_vld is high after the 7th rising edge, counting the edge that samples in_vld high. out_vld repeats the in_vld pattern with the same delay, including gaps and deassertion.
- R4: For d=3, one is added to the truncated quotient exactly when the remainder is 2. For example, 2/3 gives 1 and 1/3 gives 0.
- R5: For d=7, one is added exactly when the remainder is 4, 5 or 6. For example, 3/7 gives 0, 4/7 gives 1 and 6/7 gives 1.
- R6: For d=5 and d=6, one is added when the remainder is 3 or more. For d=9, one is added when the remainder is 5 or more.
- R7: Before rounding, the quotient equals floor(n/d) for every numerator and every supported d. Rounding is applied only to this exact value.
- R8: Any other 4-bit select value (0, 1, 2, 4, 8, 10 to 15) gives out_quo = 0. Its out_vld timing is the same as for a supported select.
- R9: A new request is accepted on every clock. Back-to-back requests with different denominators each return their own correct quotient, in order.
- R10: A synchronous reset clears every in-flight request. While rst is high, and for the next 7 cycles unless new requests are made, out_vld is 0 and out_quo is 0. Whenever out_vld is 0, out_quo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Request strobe |
| in_num | input | 13 | Unsigned numerator |
| in_den | input | 4 | Denominator select, value equals denominator |
| out_vld | output | 1 | Result strobe |
| out_quo | output | 13 | Rounded quotient, zero when not valid or unsupported |

## Verification
Each result is due on the seventh rising edge, counting the edge that takes the request. out_quo is also defined as zero in every cycle without a result. The bench keeps a seven-deep behavioural shift model of expected strobe and quotient. It compares both outputs on every falling edge, so every cycle is checked, idle or not. A separate hand-counted check confirms that a single request stays invisible after six edges and appears after the seventh. A mid-stream reset empties the model exactly as the pipeline must be emptied.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

   // number of supported denominators and the largest of them
   localparam int NDEN    = 5;
   localparam int DEN_MAX = 9;

   // supported denominator for a given table slot
   function automatic int unsigned den_of(input int i);
      case (i)
         0:       return 3;
         1:       return 5;
         2:       return 6;
         3:       return 7;
         default: return 9;
      endcase
   endfunction

   // scaled reciprocal, always rounded down so the estimate never overshoots
   function automatic int unsigned recip(input int unsigned d, input int s);
      return (32'd1 << s) / d;
   endfunction

endpackage

// File: rtl/rcd_cmul.sv
module rcd_cmul #(
   parameter int          IN_W  = 13,
   parameter int          OUT_W = 28,
   parameter int unsigned K     = 3
) (
   input  logic [IN_W-1:0]  a,
   output logic [OUT_W-1:0] y
);
   localparam logic [31:0] KB = 32'(K);
   localparam int          KW = $clog2(K + 1);

   if (K == 0) begin : g_bad_k
      $error("rcd_cmul: constant must be non-zero");
   end
   if (OUT_W < IN_W + KW) begin : g_bad_w
      $error("rcd_cmul: output too narrow for product");
   end

   // one shifted copy of the operand per set bit of the constant
   always_comb begin
      y = '0;
      for (int b = 0; b < KW; b++) begin
         if (KB[b]) y = y + (OUT_W'(a) << b);
      end
   end
endmodule

// File: rtl/rcd_fix.sv
module rcd_fix #(
   parameter int QW = 13,
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          chk_en,
   input  logic [QW-1:0] q_in,
   input  logic [RW-1:0] r_in,
   input  logic [RW-1:0] d_in,
   output logic [QW-1:0] q_out,
   output logic [RW-1:0] r_out
);
   // estimate is at most one low, so one conditional subtract suffices
   always_comb begin
      if (r_in >= d_in) begin
         q_out = q_in + QW'(1);
         r_out = r_in - d_in;
      end else begin
         q_out = q_in;
         r_out = r_in;
      end
   end

   // R7
   fix_rem_chk: assert property (@(posedge clk) disable iff (rst)
      chk_en |-> (r_out < d_in));

   // R7
   fix_in_window_chk: assert property (@(posedge clk) disable iff (rst)
      chk_en |-> ({1'b0, r_in} < {d_in, 1'b0}));
endmodule

// File: rtl/rnd_cdiv.sv
module rnd_cdiv #(
   parameter int NUM_W = 13,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic [NUM_W-1:0] in_num,
   input  logic [SEL_W-1:0] in_den,
   output logic             out_vld,
   output logic [NUM_W-1:0] out_quo
);
   import rcd_pkg::*;

   localparam int RS    = NUM_W + 2;              // reciprocal scale
   localparam int PW    = NUM_W + RS;             // estimate product width
   localparam int DW    = NUM_W + 4;              // d*q width
   localparam int RW    = $clog2(2 * DEN_MAX);    // remainder width
   localparam int IW    = $clog2(NDEN);           // table index width
   localparam int LAT   = 7;
   localparam int AGE_W = $clog2(LAT + 1);
   localparam int MAXQ  = ((2 ** NUM_W - 1) * 2 + 3) / 6;

   if (SEL_W < $clog2(DEN_MAX + 1)) begin : g_bad_sel
      $error("rnd_cdiv: select too narrow for largest denominator");
   end
   if (NUM_W < 4 || NUM_W > 20) begin : g_bad_num
      $error("rnd_cdiv: numerator width out of range");
   end

   // ---------------- stage 1: capture ----------------
   logic             s1_vld;
   logic [NUM_W-1:0] s1_n;
   logic [SEL_W-1:0] s1_sel;

   always_ff @(posedge clk) begin
      if (rst) s1_vld <= 1'b0;
      else     s1_vld <= in_vld;
      s1_n   <= in_num;
      s1_sel <= in_den;
   end

   // ---------------- stage 2: select decode ----------------
   logic [NDEN-1:0] hit;
   logic [IW-1:0]   idx1;

   for (genvar i = 0; i < NDEN; i++) begin : g_hit
      assign hit[i] = (s1_sel == SEL_W'(den_of(i)));
   end

   always_comb begin
      idx1 = '0;
      for (int i = 0; i < NDEN; i++) begin
         if (hit[i]) idx1 = IW'(i);
      end
   end

   logic             s2_vld, s2_ok;
   logic [NUM_W-1:0] s2_n;
   logic [IW-1:0]    s2_idx;

   always_ff @(posedge clk) begin
      if (rst) s2_vld <= 1'b0;
      else     s2_vld <= s1_vld;
      s2_ok  <= |hit;
      s2_n   <= s1_n;
      s2_idx <= idx1;
   end

   // ---------------- stage 3: reciprocal estimate ----------------
   logic [PW-1:0] prod [NDEN];

   for (genvar i = 0; i < NDEN; i++) begin : g_est
      rcd_cmul #(.IN_W(NUM_W), .OUT_W(PW), .K(recip(den_of(i), RS))) u_est (
         .a (s2_n),
         .y (prod[i])
      );
   end

   logic [PW-1:0] prod_sel;
   assign prod_sel = s2_ok ? prod[s2_idx] : '0;

   logic             s3_vld, s3_ok;
   logic [NUM_W-1:0] s3_n, s3_q;
   logic [IW-1:0]    s3_idx;

   always_ff @(posedge clk) begin
      if (rst) s3_vld <= 1'b0;
      else     s3_vld <= s2_vld;
      s3_ok  <= s2_ok;
      s3_n   <= s2_n;
      s3_idx <= s2_idx;
      s3_q   <= NUM_W'(prod_sel >> RS);
   end

   // ---------------- stage 4: d * estimate by shift-add ----------------
   logic [DW-1:0] dq [NDEN];

   for (genvar i = 0; i < NDEN; i++) begin : g_back
      rcd_cmul #(.IN_W(NUM_W), .OUT_W(DW), .K(den_of(i))) u_back (
         .a (s3_q),
         .y (dq[i])
      );
   end

   logic             s4_vld, s4_ok;
   logic [NUM_W-1:0] s4_n, s4_q;
   logic [IW-1:0]    s4_idx;
   logic [DW-1:0]    s4_dq;

   always_ff @(posedge clk) begin
      if (rst) s4_vld <= 1'b0;
      else     s4_vld <= s3_vld;
      s4_ok  <= s3_ok;
      s4_n   <= s3_n;
      s4_q   <= s3_q;
      s4_idx <= s3_idx;
      s4_dq  <= dq[s3_idx];
   end

   // ---------------- stage 5: remainder ----------------
   logic [DW-1:0] diff4;
   logic [RW-1:0] d4;
   assign diff4 = DW'(s4_n) - s4_dq;
   assign d4    = RW'(den_of(int'(s4_idx)));

   // R7
   est_window_chk: assert property (@(posedge clk) disable iff (rst)
      (s4_vld && s4_ok) |-> (diff4 < DW'(2 * d4)));

   logic             s5_vld, s5_ok;
   logic [NUM_W-1:0] s5_q;
   logic [RW-1:0]    s5_r;
   logic [IW-1:0]    s5_idx;

   always_ff @(posedge clk) begin
      if (rst) s5_vld <= 1'b0;
      else     s5_vld <= s4_vld;
      s5_ok  <= s4_ok;
      s5_q   <= s4_q;
      s5_r   <= RW'(diff4);
      s5_idx <= s4_idx;
   end

   // ---------------- stage 6: correction ----------------
   logic [RW-1:0]    d5, fx_r;
   logic [NUM_W-1:0] fx_q;
   assign d5 = RW'(den_of(int'(s5_idx)));

   rcd_fix #(.QW(NUM_W), .RW(RW)) u_fix (
      .clk    (clk),
      .rst    (rst),
      .chk_en (s5_vld && s5_ok),
      .q_in   (s5_q),
      .r_in   (s5_r),
      .d_in   (d5),
      .q_out  (fx_q),
      .r_out  (fx_r)
   );

   logic             s6_vld, s6_ok;
   logic [NUM_W-1:0] s6_q;
   logic [RW-1:0]    s6_r;
   logic [IW-1:0]    s6_idx;

   always_ff @(posedge clk) begin
      if (rst) s6_vld <= 1'b0;
      else     s6_vld <= s5_vld;
      s6_ok  <= s5_ok;
      s6_q   <= fx_q;
      s6_r   <= fx_r;
      s6_idx <= s5_idx;
   end

   // ---------------- stage 7: round to nearest ----------------
   logic [RW-1:0] d6;
   logic          rnd_up;
   assign d6     = RW'(den_of(int'(s6_idx)));
   assign rnd_up = ({s6_r, 1'b0} >= {1'b0, d6});

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
         out_quo <= '0;
      end else begin
         out_vld <= s6_vld;
         out_quo <= (s6_vld && s6_ok) ? s6_q + NUM_W'(rnd_up) : '0;
      end
   end

   // ---------------- latency checker ----------------
   logic [AGE_W-1:0] age;
   always_ff @(posedge clk) begin
      if (rst)                    age <= '0;
      else if (age != AGE_W'(LAT)) age <= age + AGE_W'(1);
   end

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (rst)
      (age == AGE_W'(LAT)) |-> (out_vld == $past(in_vld, 7)));

   // R1
   quo_range_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_quo <= NUM_W'(MAXQ)));

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !out_vld |-> (out_quo == '0));
endmodule

// File: tb/tb_rnd_cdiv.sv
module tb_rnd_cdiv;
   localparam int NW  = 13;
   localparam int SW  = 4;
   localparam int LAT = 7;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_vld = 1'b0;
   logic [NW-1:0] in_num = '0;
   logic [SW-1:0] in_den = '0;
   logic          out_vld;
   logic [NW-1:0] out_quo;

   rnd_cdiv #(.NUM_W(NW), .SEL_W(SW)) dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_num(in_num),
      .in_den(in_den), .out_vld(out_vld), .out_quo(out_quo)
   );

   always #4 clk = ~clk;   // 125 MHz

   int    checks = 0;
   int    errors = 0;
   string cur_tag = "R10";

   bit    mv [LAT];
   int    mq [LAT];
   string mt [LAT];

   // rounded quotient from the requirements: floor((2n+d)/(2d)), zero if unsupported
   function automatic int ref_quo(int n, int d);
      if (d == 3 || d == 5 || d == 6 || d == 7 || d == 9) return (2 * n + d) / (2 * d);
      return 0;
   endfunction

   // behavioural model: a seven-deep queue of expectations
   always @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < LAT; k++) begin
            mv[k] = 1'b0; mq[k] = 0; mt[k] = cur_tag;
         end
      end else begin
         for (int k = LAT - 1; k > 0; k--) begin
            mv[k] = mv[k-1]; mq[k] = mq[k-1]; mt[k] = mt[k-1];
         end
         mv[0] = in_vld;
         mq[0] = in_vld ? ref_quo(int'(in_num), int'(in_den)) : 0;
         mt[0] = cur_tag;
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      checks++;
      if (out_vld !== mv[LAT-1] || int'(out_quo) !== mq[LAT-1]) begin
         errors++;
         $display("FAIL %s: vld/quo actual %0b/%0d expected %0b/%0d",
                  mt[LAT-1], out_vld, out_quo, mv[LAT-1], mq[LAT-1]);
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(bit v, int n, int d);
      in_vld = v; in_num = NW'(n); in_den = SW'(d);
      @(negedge clk);
   endtask

   task automatic idle(int c);
      for (int i = 0; i < c; i++) drive(1'b0, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R3: watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk(out_vld == 1'b0 && out_quo == '0, "R10", int'(out_vld), 0);
      rst = 1'b0;
      idle(2);

      // R3 / R4: one request, counted by hand
      cur_tag = "R3";
      drive(1'b1, 2, 3);
      idle(5);
      chk(out_vld == 1'b0, "R3", int'(out_vld), 0);
      idle(1);
      chk(out_vld == 1'b1 && out_quo == 1, "R4", int'(out_quo), 1);
      idle(3);

      // R4, R5, R6: remainder thresholds
      cur_tag = "R4";
      for (int n = 0; n < 9; n++) drive(1'b1, n, 3);
      cur_tag = "R5";
      for (int n = 0; n < 15; n++) drive(1'b1, n, 7);
      cur_tag = "R6";
      for (int n = 0; n < 19; n++) begin
         drive(1'b1, n, 5);
         drive(1'b1, n, 6);
         drive(1'b1, n, 9);
      end
      idle(LAT + 1);

      // R8: unsupported selects, with gaps
      cur_tag = "R8";
      for (int s = 0; s < 16; s++) begin
         if (s != 3 && s != 5 && s != 6 && s != 7 && s != 9) begin
            drive(1'b1, 8191, s);
            drive(1'b0, 0, 0);
         end
      end
      idle(LAT + 1);

      // R2 / R7: every numerator for every denominator, back to back
      cur_tag = "R7";
      for (int di = 0; di < 5; di++) begin
         int d;
         d = (di == 0) ? 3 : (di == 1) ? 5 : (di == 2) ? 6 : (di == 3) ? 7 : 9;
         for (int n = 0; n < 8192; n++) drive(1'b1, n, d);
      end
      cur_tag = "R2";
      drive(1'b1, 8191, 3);
      drive(1'b1, 0, 9);
      drive(1'b1, 8191, 9);
      idle(LAT + 1);

      // R9 / R3: mixed denominators with an irregular strobe
      cur_tag = "R9";
      for (int k = 0; k < 400; k++) begin
         int d;
         case (k % 8)
            0: d = 3; 1: d = 9; 2: d = 5; 3: d = 7;
            4: d = 6; 5: d = 12; 6: d = 3; default: d = 7;
         endcase
         drive((k % 5) != 3, (k * 2749 + 113) % 8192, d);
      end

      // R10: reset while the pipeline is full
      cur_tag = "R10";
      for (int k = 0; k < 4; k++) drive(1'b1, 100 + k, 7);
      rst = 1'b1;
      drive(1'b1, 500, 3);
      rst = 1'b0;
      idle(LAT + 2);
      chk(out_vld == 1'b0 && out_quo == '0, "R10", int'(out_quo), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule